// File: doc/BRIEF.md
# Transmit Enable Timeout Gate

This block stands between the transmit pins of a communication controller and the control inputs of a differential line driver. While the controller holds its active-low transmit enable asserted and nothing forbids sending, the gate passes the transmit data bit through to the driver. In every other case it holds the driver in the idle state. Sending is forbidden in any of these cases: the transceiver is in its low-power standby mode, the die is flagged as too hot, either supply is flagged as below its threshold, or the watchdog has tripped.

The watchdog guards against a controller that keeps the bus occupied without end. It counts ticks of a slow timebase for as long as the enable stays asserted without a break. When the count reaches a parameterised limit, the gate locks the driver to idle and raises a one-cycle stuck-enable pulse, which the diagnostic register latches. The lock stays in place until the enable has been seen released. A new assertion then opens a full new window. The gate never clears the diagnostic flag itself. All outputs are registered and reset synchronously.

Top module: `txen_timeout_gate`

## Requirements
- R1: While `rst` is high, and after it is released until a later edge changes them, `drv_en`, `drv_data` and `stuck_pulse` are all 0.
- R2: When `tx_en_n` is 0, `mode_normal` is 1, `over_temp` is 0, `vcc_ok` and `vio_ok` are 1 and the watchdog is not locked, `drv_en` is 1 and `drv_data` equals `tx_data` after the next clock edge. A value of 0 on `tx_data` (an open input) therefore drives dominant Data_0.
- R3: When `tx_en_n` is 1, `drv_en` and `drv_data` are 0 after the next edge (idle).
- R4: When `mode_normal` is 0 (standby), the driver is idle after the next edge, whatever the other inputs are.
- R5: When `over_temp` is 1, the driver is idle after the next edge.
- R6: When `vcc_ok` or `vio_ok` is 0, the driver is idle after the next edge.
- R7: After an edge that samples `tick`=1 while `tx_en_n`=0, and that brings the number of such edges since `tx_en_n` was last 1 to `TIMEOUT_TICKS`, `stuck_pulse` is 1 for exactly one cycle. `drv_en` is 0 from the following edge on.
- R8: An edge that samples `tx_en_n`=1 restarts the count. Two low windows of `TIMEOUT_TICKS`-1 ticks each, separated by a release, raise no pulse.
- R9: Once tripped, the driver stays idle and no further pulse is raised while `tx_en_n` stays 0, even as ticks go on. After a release, a new low window passes data again and trips only after a full `TIMEOUT_TICKS` ticks.
- R10: The count runs regardless of mode, temperature and supply flags. A window spent gated by over-temperature still trips on its `TIMEOUT_TICKS`-th tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase strobe for the watchdog |
| tx_en_n | input | 1 | Transmit enable from the controller, active low |
| tx_data | input | 1 | Transmit data bit from the controller |
| mode_normal | input | 1 | 1 = normal mode, 0 = standby |
| over_temp | input | 1 | Over-temperature flag, 1 = too hot |
| vcc_ok | input | 1 | Main supply good, 0 = undervoltage |
| vio_ok | input | 1 | I/O supply good, 0 = undervoltage |
| drv_en | output | 1 | Driver active (1) or idle (0) |
| drv_data | output | 1 | Bit to drive, 0 whenever idle |
| stuck_pulse | output | 1 | One-cycle pulse on watchdog trip, for the diagnostic register |

## Verification
The bench goes after the watchdog's boundaries. It checks that the trip comes on exactly the `TIMEOUT_TICKS`-th tick and not one earlier: an off-by-one counter would fire a tick early or a tick late. It checks that a single release between two near-full windows prevents a trip: a counter that never restarts would fire a false fault in the second window. It also checks that the lock outlives further ticks without raising a second pulse, and that it clears only on release: a lock that self-cleared would let a babbling controller back onto the bus. Finally, the bench runs a timeout window gated by over-temperature, to catch a counter wrongly tied to the output gating, and it drives each fault input alone to catch a missing term in the enable condition.

// File: rtl/txg_pkg.sv
package txg_pkg;
  // Driver command pair, idle encoded as all zero.
  typedef struct packed {
    logic en;
    logic data;
  } drv_cmd_t;

  localparam drv_cmd_t DRV_IDLE = '{en: 1'b0, data: 1'b0};
endpackage

// File: rtl/txg_watchdog.sv
module txg_watchdog #(
  parameter int TIMEOUT_TICKS = 7700
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic tx_en_n,
  output logic locked,
  output logic trip_pulse
);
  localparam int CW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q    <= '0;
      locked     <= 1'b0;
      trip_pulse <= 1'b0;
    end else begin
      trip_pulse <= 1'b0;
      if (tx_en_n) begin
        // release seen: fresh window, lock dropped
        count_q <= '0;
        locked  <= 1'b0;
      end else if (!locked && tick) begin
        if (count_q == LAST) begin
          count_q    <= '0;
          locked     <= 1'b1;
          trip_pulse <= 1'b1;
        end else begin
          count_q <= count_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/txg_drive_stage.sv
module txg_drive_stage
  import txg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tx_en_n,
  input  logic     tx_data,
  input  logic     mode_normal,
  input  logic     over_temp,
  input  logic     vcc_ok,
  input  logic     vio_ok,
  input  logic     locked,
  output drv_cmd_t cmd_q
);
  logic     allow;
  drv_cmd_t cmd_d;

  always_comb begin
    allow = !tx_en_n && mode_normal && !over_temp && vcc_ok && vio_ok && !locked;
    cmd_d = allow ? '{en: 1'b1, data: tx_data} : DRV_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) cmd_q <= DRV_IDLE;
    else     cmd_q <= cmd_d;
  end
endmodule

// File: rtl/txen_timeout_gate.sv
module txen_timeout_gate
  import txg_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 7700
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic tx_en_n,
  input  logic tx_data,
  input  logic mode_normal,
  input  logic over_temp,
  input  logic vcc_ok,
  input  logic vio_ok,
  output logic drv_en,
  output logic drv_data,
  output logic stuck_pulse
);
  logic     locked;
  drv_cmd_t cmd;

  txg_watchdog #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_wdog (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .tx_en_n    (tx_en_n),
    .locked     (locked),
    .trip_pulse (stuck_pulse)
  );

  txg_drive_stage u_drive (
    .clk         (clk),
    .rst         (rst),
    .tx_en_n     (tx_en_n),
    .tx_data     (tx_data),
    .mode_normal (mode_normal),
    .over_temp   (over_temp),
    .vcc_ok      (vcc_ok),
    .vio_ok      (vio_ok),
    .locked      (locked),
    .cmd_q       (cmd)
  );

  assign drv_en   = cmd.en;
  assign drv_data = cmd.data;
endmodule

// File: rtl/txen_timeout_gate_chk.sv
module txen_timeout_gate_chk (
  input logic clk,
  input logic rst,
  input logic tx_en_n,
  input logic tx_data,
  input logic mode_normal,
  input logic over_temp,
  input logic vcc_ok,
  input logic vio_ok,
  input logic drv_en,
  input logic drv_data,
  input logic stuck_pulse
);
  AST_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (rst) drv_en |-> drv_data == $past(tx_data)); // R2
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst) tx_en_n |=> !drv_en); // R3
  AST_IDLE_DATA_LOW: assert property (@(posedge clk) disable iff (rst) !drv_en |-> !drv_data); // R3
  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (rst) !mode_normal |=> !drv_en); // R4
  AST_IDLE_HOT: assert property (@(posedge clk) disable iff (rst) over_temp |=> !drv_en); // R5
  AST_IDLE_UNDERVOLT: assert property (@(posedge clk) disable iff (rst) !(vcc_ok && vio_ok) |=> !drv_en); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst) stuck_pulse |=> !stuck_pulse); // R7
  AST_PULSE_WHILE_LOW: assert property (@(posedge clk) disable iff (rst) stuck_pulse |-> !$past(tx_en_n)); // R7
  AST_LOCK_IDLES: assert property (@(posedge clk) disable iff (rst) stuck_pulse |=> !drv_en); // R9
endmodule

bind txen_timeout_gate txen_timeout_gate_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .tx_en_n     (tx_en_n),
  .tx_data     (tx_data),
  .mode_normal (mode_normal),
  .over_temp   (over_temp),
  .vcc_ok      (vcc_ok),
  .vio_ok      (vio_ok),
  .drv_en      (drv_en),
  .drv_data    (drv_data),
  .stuck_pulse (stuck_pulse)
);

// File: tb/txen_timeout_gate_bench.sv
`timescale 1ns/1ps
module txen_timeout_gate_bench;
  localparam int TO = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, tx_en_n = 1'b1, tx_data = 1'b0;
  logic mode_normal = 1'b1, over_temp = 1'b0, vcc_ok = 1'b1, vio_ok = 1'b1;
  logic drv_en, drv_data, stuck_pulse;

  int checks = 0;
  int errors = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  txen_timeout_gate #(.TIMEOUT_TICKS(TO)) u_txen_timeout_gate (
    .clk(clk), .rst(rst), .tick(tick), .tx_en_n(tx_en_n), .tx_data(tx_data),
    .mode_normal(mode_normal), .over_temp(over_temp), .vcc_ok(vcc_ok),
    .vio_ok(vio_ok), .drv_en(drv_en), .drv_data(drv_data), .stuck_pulse(stuck_pulse)
  );

  task automatic compare(input logic [2:0] exp, input string tag);
    checks++;
    if ({drv_en, drv_data, stuck_pulse} !== exp) begin
      errors++;
      $display("FAIL %s: en/data/pulse actual %b expected %b", tag,
               {drv_en, drv_data, stuck_pulse}, exp);
    end
  endtask

  // Monitor: pops expectations queued for the edge just taken.
  initial begin
    forever begin
      @(posedge clk);
      #4;
      while (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  // Driver: apply inputs before an edge, queue what must appear after it.
  task automatic step(input logic en_n, input logic d, input logic tk,
                      input logic e_en, input logic e_d, input logic e_p,
                      input string tag);
    @(negedge clk);
    tx_en_n = en_n; tx_data = d; tick = tk;
    @(posedge clk);
    #2;
    exp_q.push_back({e_en, e_d, e_p});
    tag_q.push_back(tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    compare(3'b000, "R1 in reset");
    @(negedge clk); rst = 1'b0;
    step(1, 0, 0, 0, 0, 0, "R1 after release");

    // R2 pass-through, both data values
    step(0, 1, 0, 1, 1, 0, "R2 data 1");
    step(0, 0, 0, 1, 0, 0, "R2 data 0");
    step(0, 1, 0, 1, 1, 0, "R2 data 1 again");
    // R3 release
    step(1, 1, 0, 0, 0, 0, "R3 release idles");

    // R4 standby
    @(negedge clk); mode_normal = 1'b0;
    step(0, 1, 0, 0, 0, 0, "R4 standby idles");
    @(negedge clk); mode_normal = 1'b1;
    step(0, 1, 0, 1, 1, 0, "R4 back to normal");
    // R5 over-temperature
    @(negedge clk); over_temp = 1'b1;
    step(0, 1, 0, 0, 0, 0, "R5 hot idles");
    @(negedge clk); over_temp = 1'b0;
    // R6 undervoltage on each supply
    @(negedge clk); vcc_ok = 1'b0;
    step(0, 1, 0, 0, 0, 0, "R6 vcc low idles");
    @(negedge clk); vcc_ok = 1'b1; vio_ok = 1'b0;
    step(0, 1, 0, 0, 0, 0, "R6 vio low idles");
    @(negedge clk); vio_ok = 1'b1;
    step(1, 0, 0, 0, 0, 0, "R3 release before timeout");

    // R7 exact trip, then R9 lock held
    for (int i = 0; i < TO - 1; i++) step(0, 1, 1, 1, 1, 0, "R7 before limit");
    step(0, 1, 1, 1, 1, 1, "R7 pulse on last tick");
    step(0, 1, 0, 0, 0, 0, "R7 idle after trip");
    for (int i = 0; i < TO + 1; i++) step(0, 1, 1, 0, 0, 0, "R9 lock holds, no repulse");
    step(1, 1, 0, 0, 0, 0, "R9 release");
    for (int i = 0; i < TO - 1; i++) step(0, 0, 1, 1, 0, 0, "R9 fresh window passes");
    step(0, 0, 1, 1, 0, 1, "R9 full window trips again");
    step(1, 0, 0, 0, 0, 0, "R9 release again");

    // R8 restart between two near-full windows
    for (int i = 0; i < TO - 1; i++) step(0, 1, 1, 1, 1, 0, "R8 first window");
    step(1, 1, 1, 0, 0, 0, "R8 release with tick");
    for (int i = 0; i < TO - 1; i++) step(0, 1, 1, 1, 1, 0, "R8 second window no trip");
    step(0, 1, 1, 1, 1, 1, "R8 trip on full count");
    step(1, 1, 0, 0, 0, 0, "R8 release");

    // R10 count runs while gated hot
    @(negedge clk); over_temp = 1'b1;
    for (int i = 0; i < TO - 1; i++) step(0, 1, 1, 0, 0, 0, "R10 hot window");
    step(0, 1, 1, 0, 0, 1, "R10 trips while hot");
    @(negedge clk); over_temp = 1'b0;
    step(0, 1, 0, 0, 0, 0, "R10 locked after cooling");
    step(1, 1, 0, 0, 0, 0, "R10 release");

    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule